// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Target

This block is the serial target side of a battery-backed clock device. A host selects it with an active-high enable, sends one command byte, and then moves any number of data bytes over SCK/MOSI/MISO. The command byte carries a direction bit and a starting address. Later bytes go to or come from consecutive registers. The register space holds the BCD time and date, two alarm sets, a control byte, a status byte, a trickle-charge setting and a block of general user memory.

A write-protect flag in the control byte blocks every host write except writes to the control byte itself. Clearing the whole control byte while protection is on takes two writes. A parallel port lets a neighbouring time-keeping engine load the seven time registers directly, and the block exposes those registers and the control byte to it. The serial inputs are sampled in the system clock domain. Each SCK phase must last at least three system clocks.

Top module: `spiRtcSlave`

## Requirements
- R1: A transaction lasts while `spiEn` is high. Bytes move most significant bit first. MOSI is sampled on SCK rising edges and MISO changes after SCK falling edges. The first byte is the command: bit 7 = 1 means write, bit 7 = 0 means read, and bits 6..0 give the start address. In a read, each byte after the command returns the addressed register. MISO is 0 whenever the block is not selected.
- R2: While enable stays high, each further data byte uses the next address. This holds for reads and for writes.
- R3: Addresses 0x00 to 0x1F form one region for increment. The address after 0x1F is 0x00.
- R4: User memory occupies 0x20 to 0x20+RAM_BYTES-1 (0x7F by default). The address after its last byte is 0x20.
- R5: Bit 6 of the control byte (address 0x0F) is the write-protect flag. While it is 1, host writes to every other address are ignored.
- R6: Only bits 6, 2, 1 and 0 of the control byte exist; the other bits read 0. A host write to control while protection is on changes bit 6 only. With protection off, a write loads all implemented bits.
- R7: Register map: 0x00 to 0x06 are time and date bytes, 0x07 to 0x0E are alarm bytes, and 0x11 is the trickle byte. All of these are 8-bit read/write. 0x10 reads the `statusIn` input and ignores writes. 0x12 to 0x1F read 0 and ignore writes.
- R8: Reset clears every register to 0 except control, which resets to 0x40.
- R9: A local write pulse stores `locData` in time register `locAddr` (0 to 6), whatever the protection state. `locAddr` = 7 has no effect. If a host write to the same register lands in the same cycle, the host value wins.
- R10: `timeOut` holds time register k in bits 8k+7..8k, and `ctrlOut` holds the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiEn | input | 1 | Serial select, active high |
| spiSck | input | 1 | Serial clock, idle low |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| locWrEn | input | 1 | Local time-register write pulse |
| locAddr | input | 3 | Local target register (0 to 6) |
| locData | input | 8 | Local write data |
| statusIn | input | 8 | Value returned at the status address |
| timeOut | output | 56 | Seven time registers, register 0 in the low byte |
| ctrlOut | output | 8 | Control byte |

## Verification
Directed cases walk the edges of the map, each chosen to split behaviour that a random run would blur:
- Writes while protected, which must leave registers unchanged.
- The two-step control release, which must first clear only bit 6.
- Bursts across 0x1F and across the top of user memory, which tell a regional wrap from a plain 7-bit wrap.
- Reserved and status addresses.
- A local write that lands in the same cycle as a host write.

Constrained-random bursts then mix direction, start address, length and protection state. A reference model built from the map and the protection rules predicts every read byte, so a wrong address step or a wrong gate shows up as a byte mismatch.

// File: rtl/spiRtcPkg.sv
package spiRtcPkg;

  localparam logic [6:0] CTRL_ADDR = 7'h0F;
  localparam logic [6:0] STAT_ADDR = 7'h10;
  localparam logic [6:0] TRKL_ADDR = 7'h11;
  localparam logic [6:0] RAM_BASE  = 7'h20;
  localparam int         LOW_REGS  = 15;      // 0x00..0x0E
  localparam int         TIME_REGS = 7;       // 0x00..0x06
  localparam int         WP_BIT    = 6;
  localparam logic [7:0] WP_MASK   = 8'h40;
  localparam logic [7:0] CTRL_MASK = 8'h47;
  localparam logic [7:0] CTRL_RESET = 8'h40;

  typedef enum logic [1:0] {PH_ADDR, PH_WRITE, PH_READ} phase_t;

  // strobes from the serial control to the register datapath
  typedef struct packed {
    logic       idle;
    logic       wrStb;
    logic       loadOut;
    logic       shiftOut;
    logic [6:0] addr;
    logic [7:0] data;
  } spiStb_t;

  // next burst address: low region wraps in 0x00..0x1F, memory wraps to its base
  function automatic logic [6:0] nextAddr(input logic [6:0] a, input logic [6:0] top);
    if (a < RAM_BASE) return {2'b00, a[4:0] + 5'd1};
    else if (a >= top) return RAM_BASE;
    else return a + 7'd1;
  endfunction

endpackage

// File: rtl/spiRtcCtrl.sv
module spiRtcCtrl
  import spiRtcPkg::*;
#(
  parameter int RAM_BYTES = 96
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    spiEn,
  input  logic    spiSck,
  input  logic    spiMosi,
  output spiStb_t stb
);

  localparam logic [6:0] RAM_TOP = 7'(int'(RAM_BASE) + RAM_BYTES - 1);

  logic       enS, sckS1, sckS2, mosiS;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic [6:0] addrPtr;
  phase_t     phase;
  logic       sckRise, sckFall;
  logic [7:0] byteNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enS   <= 1'b0;
      sckS1 <= 1'b0;
      sckS2 <= 1'b0;
      mosiS <= 1'b0;
    end else begin
      enS   <= spiEn;
      sckS1 <= spiSck;
      sckS2 <= sckS1;
      mosiS <= spiMosi;
    end
  end

  assign sckRise  = enS & sckS1 & ~sckS2;
  assign sckFall  = enS & ~sckS1 & sckS2;
  assign byteNext = {shiftIn, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
      addrPtr <= '0;
      phase   <= PH_ADDR;
      stb     <= '0;
    end else begin
      stb.wrStb    <= 1'b0;
      stb.loadOut  <= 1'b0;
      stb.shiftOut <= 1'b0;
      stb.idle     <= ~enS;
      if (!enS) begin
        bitCnt <= '0;
        phase  <= PH_ADDR;
      end else if (sckRise) begin
        shiftIn <= byteNext[6:0];
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          case (phase)
            PH_ADDR: begin
              if (byteNext[7]) begin
                phase   <= PH_WRITE;
                addrPtr <= byteNext[6:0];
              end else begin
                phase       <= PH_READ;
                stb.loadOut <= 1'b1;
                stb.addr    <= byteNext[6:0];
                addrPtr     <= nextAddr(byteNext[6:0], RAM_TOP);
              end
            end
            PH_WRITE: begin
              stb.wrStb <= 1'b1;
              stb.addr  <= addrPtr;
              stb.data  <= byteNext;
              addrPtr   <= nextAddr(addrPtr, RAM_TOP);
            end
            PH_READ: begin
              stb.loadOut <= 1'b1;
              stb.addr    <= addrPtr;
              addrPtr     <= nextAddr(addrPtr, RAM_TOP);
            end
            default: phase <= PH_ADDR;
          endcase
        end
      end else if (sckFall && bitCnt != 3'd0) begin
        stb.shiftOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spiRtcRegs.sv
module spiRtcRegs
  import spiRtcPkg::*;
#(
  parameter int RAM_BYTES = 96
) (
  input  logic          clk,
  input  logic          rstN,
  input  spiStb_t       stb,
  input  logic          locWrEn,
  input  logic [2:0]    locAddr,
  input  logic [7:0]    locData,
  input  logic [7:0]    statusIn,
  output logic          spiMiso,
  output logic [8*TIME_REGS-1:0] timeOut,
  output logic [7:0]    ctrlOut
);

  localparam int         RAM_IDX_W = $clog2(RAM_BYTES);
  localparam logic [6:0] RAM_TOP   = 7'(int'(RAM_BASE) + RAM_BYTES - 1);

  logic [7:0] lowRegs [LOW_REGS];
  logic [7:0] ramMem  [RAM_BYTES];
  logic [7:0] ctrlReg, trkReg, outShift, rdData;
  logic       wpOn, inRam, locHit;
  logic [RAM_IDX_W-1:0] ramIdx;

  assign wpOn   = ctrlReg[WP_BIT];
  assign inRam  = (stb.addr >= RAM_BASE) && (stb.addr <= RAM_TOP);
  assign ramIdx = RAM_IDX_W'(stb.addr - RAM_BASE);
  assign locHit = locWrEn && ({1'b0, locAddr} < 4'(TIME_REGS));

  // read selection for the addressed byte
  always_comb begin
    rdData = '0;
    if (stb.addr < CTRL_ADDR)       rdData = lowRegs[stb.addr[3:0]];
    else if (stb.addr == CTRL_ADDR) rdData = ctrlReg;
    else if (stb.addr == STAT_ADDR) rdData = statusIn;
    else if (stb.addr == TRKL_ADDR) rdData = trkReg;
    else if (inRam)                 rdData = ramMem[ramIdx];
  end

  // clock, alarm, control and trickle bytes; host write is applied last so it wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LOW_REGS; i++) lowRegs[i] <= '0;
      ctrlReg <= CTRL_RESET;
      trkReg  <= '0;
    end else begin
      if (locHit) lowRegs[{1'b0, locAddr}] <= locData;
      if (stb.wrStb) begin
        if (stb.addr == CTRL_ADDR) begin
          if (wpOn) ctrlReg <= (ctrlReg & ~WP_MASK) | (stb.data & WP_MASK);
          else      ctrlReg <= stb.data & CTRL_MASK;
        end else if (!wpOn) begin
          if (stb.addr < CTRL_ADDR)       lowRegs[stb.addr[3:0]] <= stb.data;
          else if (stb.addr == TRKL_ADDR) trkReg <= stb.data;
        end
      end
    end
  end

  // user memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_BYTES; i++) ramMem[i] <= '0;
    end else if (stb.wrStb && !wpOn && inRam) begin
      ramMem[ramIdx] <= stb.data;
    end
  end

  // outgoing shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outShift <= '0;
    else if (stb.idle)     outShift <= '0;
    else if (stb.loadOut)  outShift <= rdData;
    else if (stb.shiftOut) outShift <= {outShift[6:0], 1'b0};
  end

  assign spiMiso = outShift[7];
  assign ctrlOut = ctrlReg;

  for (genvar g = 0; g < TIME_REGS; g++) begin : gTimeOut
    assign timeOut[8*g +: 8] = lowRegs[g];
  end

endmodule

// File: rtl/spiRtcSlave.sv
module spiRtcSlave
  import spiRtcPkg::*;
#(
  parameter int RAM_BYTES = 96
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiEn,
  input  logic        spiSck,
  input  logic        spiMosi,
  output logic        spiMiso,
  input  logic        locWrEn,
  input  logic [2:0]  locAddr,
  input  logic [7:0]  locData,
  input  logic [7:0]  statusIn,
  output logic [55:0] timeOut,
  output logic [7:0]  ctrlOut
);

  spiStb_t ctrlStb;

  spiRtcCtrl #(.RAM_BYTES(RAM_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .spiEn(spiEn), .spiSck(spiSck),
    .spiMosi(spiMosi), .stb(ctrlStb)
  );

  spiRtcRegs #(.RAM_BYTES(RAM_BYTES)) uRegs (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .locWrEn(locWrEn),
    .locAddr(locAddr), .locData(locData), .statusIn(statusIn),
    .spiMiso(spiMiso), .timeOut(timeOut), .ctrlOut(ctrlOut)
  );

endmodule

// File: rtl/spiRtcSlaveChk.sv
module spiRtcSlaveChk
  import spiRtcPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        spiMiso,
  input logic        locWrEn,
  input logic [2:0]  locAddr,
  input logic [7:0]  locData,
  input logic [55:0] timeOut,
  input logic [7:0]  ctrlOut,
  input spiStb_t     stb
);

  logic       locExpQ, spiExpQ;
  logic [2:0] locAddrQ, spiAddrQ;
  logic [7:0] locDataQ, spiDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locExpQ <= 1'b0; spiExpQ <= 1'b0;
      locAddrQ <= '0; spiAddrQ <= '0; locDataQ <= '0; spiDataQ <= '0;
    end else begin
      spiExpQ  <= stb.wrStb && !ctrlOut[WP_BIT] && (stb.addr < 7'd7);
      spiAddrQ <= stb.addr[2:0];
      spiDataQ <= stb.data;
      locExpQ  <= locWrEn && (locAddr != 3'd7) &&
                  !(stb.wrStb && !ctrlOut[WP_BIT] && stb.addr == {4'd0, locAddr});
      locAddrQ <= locAddr;
      locDataQ <= locData;
    end
  end

  AST_CTRL_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut & ~CTRL_MASK) == 8'h00);                                   // R6
  AST_WP_HOLDS_TIME: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut[WP_BIT] && !locWrEn) |=> $stable(timeOut));                 // R5
  AST_WP_TWO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut[WP_BIT] |=> (ctrlOut[5:0] == $past(ctrlOut[5:0]) && ctrlOut[7] == $past(ctrlOut[7]))); // R6
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.idle |=> !spiMiso);                                              // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.wrStb, stb.loadOut, stb.shiftOut}) <= 1);            // R2
  AST_LOCAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    locExpQ |-> timeOut[8*locAddrQ +: 8] == locDataQ);                   // R9
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    spiExpQ |-> timeOut[8*spiAddrQ +: 8] == spiDataQ);                   // R9

endmodule

bind spiRtcSlave spiRtcSlaveChk chk (
  .clk(clk), .rstN(rstN), .spiMiso(spiMiso), .locWrEn(locWrEn),
  .locAddr(locAddr), .locData(locData), .timeOut(timeOut),
  .ctrlOut(ctrlOut), .stb(ctrlStb)
);

// File: tb/spiRtcSlave_test.sv
module spiRtcSlave_test;

  localparam int RAMB = 96;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        spiEn = 1'b0, spiSck = 1'b0, spiMosi = 1'b0;
  logic        spiMiso;
  logic        locWrEn = 1'b0;
  logic [2:0]  locAddr = '0;
  logic [7:0]  locData = '0, statusIn = '0;
  logic [55:0] timeOut;
  logic [7:0]  ctrlOut;

  int nChecks = 0, nFails = 0;
  logic [7:0] txBuf [16];
  logic [7:0] rxBuf [16];

  // reference model
  logic [7:0] mLow [15];
  logic [7:0] mRam [RAMB];
  logic [7:0] mCtrl, mTrk;

  always #4 clk = ~clk;

  spiRtcSlave #(.RAM_BYTES(RAMB)) uut (
    .clk(clk), .rstN(rstN), .spiEn(spiEn), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .locWrEn(locWrEn), .locAddr(locAddr), .locData(locData),
    .statusIn(statusIn), .timeOut(timeOut), .ctrlOut(ctrlOut)
  );

  function automatic logic [6:0] nextA(input logic [6:0] a);
    if (a < 7'h20) return {2'b00, a[4:0] + 5'd1};
    else if (a >= 7'h7F) return 7'h20;
    else return a + 7'd1;
  endfunction

  function automatic logic [7:0] mRead(input logic [6:0] a);
    if (a < 7'h0F) return mLow[a[3:0]];
    if (a == 7'h0F) return mCtrl;
    if (a == 7'h10) return statusIn;
    if (a == 7'h11) return mTrk;
    if (a >= 7'h20) return mRam[a - 7'h20];
    return 8'h00;
  endfunction

  function automatic logic [55:0] mTime();
    logic [55:0] t;
    for (int i = 0; i < 7; i++) t[8*i +: 8] = mLow[i];
    return t;
  endfunction

  task automatic mWrite(input logic [6:0] a, input logic [7:0] d);
    if (a == 7'h0F) begin
      if (mCtrl[6]) mCtrl = {mCtrl[7], d[6], mCtrl[5:0]};
      else          mCtrl = d & 8'h47;
    end else if (!mCtrl[6]) begin
      if (a < 7'h0F) mLow[a[3:0]] = d;
      else if (a == 7'h11) mTrk = d;
      else if (a >= 7'h20) mRam[a - 7'h20] = d;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx, input bit collide);
    for (int b = 7; b >= 0; b--) begin
      spiMosi = tx[b];
      repeat (4) @(negedge clk);
      rx[b] = spiMiso;
      spiSck = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (collide && b == 0) locWrEn = (k == 1);
      end
      spiSck = 1'b0;
    end
  endtask

  task automatic spiTxn(input logic [7:0] cmd, input int n, input bit collideLast);
    logic [7:0] dummy;
    spiEn = 1'b1;
    spiByte(cmd, dummy, 1'b0);
    for (int i = 0; i < n; i++) spiByte(txBuf[i], rxBuf[i], collideLast && (i == n - 1));
    repeat (4) @(negedge clk);
    spiEn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic doWrite(input logic [6:0] a, input int n);
    logic [6:0] p = a;
    for (int i = 0; i < n; i++) begin mWrite(p, txBuf[i]); p = nextA(p); end
    spiTxn({1'b1, a}, n, 1'b0);
  endtask

  task automatic doRead(input logic [6:0] a, input int n, input string req);
    logic [6:0] p = a;
    for (int i = 0; i < n; i++) txBuf[i] = 8'h00;
    spiTxn({1'b0, a}, n, 1'b0);
    for (int i = 0; i < n; i++) begin check(req, rxBuf[i], mRead(p)); p = nextA(p); end
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    txBuf[0] = d;
    doWrite(a, 1);
  endtask

  task automatic localWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    locAddr = a; locData = d; locWrEn = 1'b1;
    if (a != 3'd7) mLow[a] = d;
    @(negedge clk);
    locWrEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 15; i++) mLow[i] = 8'h00;
    for (int i = 0; i < RAMB; i++) mRam[i] = 8'h00;
    mCtrl = 8'h40; mTrk = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R8 R10 reset state
    check("R8 ctrlOut reset", ctrlOut, 8'h40);
    check("R10 timeOut reset", timeOut, 56'h0);
    check("R1 miso idle", spiMiso, 1'b0);
    doRead(7'h0F, 1, "R8 control read");
    doRead(7'h00, 3, "R8 time read");

    // R5 write with protection on is ignored
    wr1(7'h00, 8'h12);
    wr1(7'h11, 8'hAB);
    doRead(7'h00, 1, "R5 protected time");
    doRead(7'h11, 1, "R5 protected trickle");
    check("R5 timeOut unchanged", timeOut, 56'h0);

    // R6 two-step release and masking
    wr1(7'h0F, 8'h00);
    check("R6 first release", ctrlOut, 8'h00);
    wr1(7'h0F, 8'hFF);
    check("R6 mask", ctrlOut, 8'h47);
    wr1(7'h0F, 8'h00);
    check("R6 step one keeps low bits", ctrlOut, 8'h07);
    wr1(7'h0F, 8'h00);
    check("R6 step two clears", ctrlOut, 8'h00);

    // R2 burst write/read of time
    for (int i = 0; i < 7; i++) txBuf[i] = 8'h10 + 8'(i) * 8'h11;
    doWrite(7'h00, 7);
    doRead(7'h00, 7, "R2 burst read");
    check("R10 timeOut burst", timeOut, mTime());

    // R3 wrap in the low region, R7 reserved bytes read 0
    txBuf[0] = 8'hE1; txBuf[1] = 8'hE2; txBuf[2] = 8'h59; txBuf[3] = 8'h42;
    doWrite(7'h1E, 4);
    doRead(7'h1E, 4, "R3 low wrap");
    check("R3 wrapped seconds", mLow[0], 8'h59);

    // R4 wrap in user memory
    txBuf[0] = 8'hC1; txBuf[1] = 8'hC2; txBuf[2] = 8'hC3;
    doWrite(7'h7E, 3);
    doRead(7'h7F, 2, "R4 memory wrap");
    check("R4 base written", mRam[0], 8'hC3);

    // R7 status, trickle and alarms
    statusIn = 8'hA5;
    wr1(7'h10, 8'hFF);
    doRead(7'h10, 1, "R7 status");
    wr1(7'h11, 8'h5A);
    for (int i = 0; i < 8; i++) txBuf[i] = 8'h80 | 8'(i);
    doWrite(7'h07, 8);
    doRead(7'h07, 11, "R7 alarm and map");

    // R9 local port with protection on
    wr1(7'h0F, 8'h40);
    localWr(3'd3, 8'h04);
    doRead(7'h03, 1, "R9 local write");
    localWr(3'd7, 8'hEE);
    check("R9 address 7 ignored", timeOut, mTime());

    // R9 same-cycle collision, host wins
    wr1(7'h0F, 8'h00);
    wr1(7'h0F, 8'h00);
    locAddr = 3'd0; locData = 8'h55;
    txBuf[0] = 8'h33;
    mWrite(7'h00, 8'h33);
    spiTxn(8'h80, 1, 1'b1);
    check("R9 host wins", timeOut[7:0], 8'h33);

    // R1 R2 random bursts
    for (int t = 0; t < 60; t++) begin
      logic [6:0] a;
      int n;
      statusIn = 8'($urandom);
      if ($urandom_range(0, 3) == 0) localWr(3'($urandom_range(0, 7)), 8'($urandom));
      a = ($urandom_range(0, 2) == 0) ? 7'($urandom_range(0, 31)) : 7'($urandom_range(32, 127));
      n = $urandom_range(1, 6);
      if ($urandom_range(0, 1) == 1) begin
        for (int i = 0; i < n; i++) txBuf[i] = 8'($urandom);
        doWrite(a, n);
      end else begin
        doRead(a, n, "R1 random read");
      end
      check("R1 miso idle after txn", spiMiso, 1'b0);
    end
    check("R10 final time", timeOut, mTime());
    check("R10 final control", ctrlOut, mCtrl);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule